// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block executes two short conditional branches taken from a 16-bit instruction stream. One branches when the overflow status flag is clear, and the other branches when the zero status flag is clear. The program counter is byte addressed. A taken branch moves it by a signed word displacement, measured from the address that follows the branch. Any other instruction word just steps the counter to the next word.

Each instruction cycle runs through four internal phases, Q1 to Q4, with one phase per clock:

- Q1 decodes the presented word.
- Q2 captures the displacement literal.
- Q3 evaluates the condition and forms the target.
- Q4 writes the program counter.

A branch that is not taken costs one instruction cycle. A taken branch costs two. The second cycle is a flush cycle in which nothing happens. The surrounding core uses `flush` to discard the word it fetched alongside the branch. It uses `pc` as the address of the word to present next.

Top module: `relbr_unit`

## Requirements
- R1: The word is sampled at the end of phase Q1. Bits [15:8] equal to 8'hE5 select the overflow-clear branch, and 8'hE1 selects the zero-clear branch. Bits [7:0] hold the displacement n.
- R2: A taken branch loads pc with (pc + 2 + 2·n) mod 2^21. Here n is bits [7:0] read as two's complement, from -128 to +127.
- R3: The overflow-clear branch is taken exactly when `flag_ovf` is 0. `flag_zero` has no influence on it.
- R4: The zero-clear branch is taken exactly when `flag_zero` is 0. `flag_ovf` has no influence on it.
- R5: Two cases advance pc by 2 at the end of Q4 and leave `flush` low: a branch whose condition fails, and any word with another upper byte.
- R6: `phase` steps 0,1,2,3,0… for Q1..Q4. pc changes only at the end of a Q4 phase.
- R7: `taken` is high only during the Q4 phase of a cycle whose branch is taken.
- R8: The instruction cycle after a taken branch is a flush cycle:
  - `flush` is high in all four phases.
  - The presented word and flags are ignored.
  - pc is held.
  - `flush` falls at its end.
- R9: pc bit 0 is always 0.
- R10: A synchronous active-high `rst` sets pc to 0, phase to Q1 and `flush` to 0, even in the middle of a cycle or a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock per Q phase |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 16 | Instruction word, valid during Q1 |
| flag_zero | input | 1 | Zero status flag, used in Q3 |
| flag_ovf | input | 1 | Overflow status flag, used in Q3 |
| pc | output | 21 | Byte-addressed program counter |
| phase | output | 2 | Current Q phase (0 = Q1 … 3 = Q4) |
| taken | output | 1 | Branch taken, high in Q4 |
| flush | output | 1 | Flush cycle in progress |

## Verification
The hardest state to reach from the ports is a taken branch whose target wraps modulo 2^21, followed by a flush cycle that is presented with a word that would itself branch. The bench reaches it from reset by taking a zero-clear branch with n = -2 from address 0, which lands at 0x1FFFFE. It then presents a taken-looking branch word with both flags clear during the flush cycle and checks that pc holds. A plain word then wraps pc back to 0. Reset is also applied in the middle of an instruction cycle and again inside a flush cycle, to check that it clears a pending flush.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

  typedef enum logic [1:0] {Q1 = 2'd0, Q2 = 2'd1, Q3 = 2'd2, Q4 = 2'd3} qphase_t;

  typedef enum logic [1:0] {K_NONE = 2'd0, K_NOV = 2'd1, K_NZ = 2'd2} br_kind_t;

  localparam logic [7:0] PFX_NOV = 8'hE5;
  localparam logic [7:0] PFX_NZ  = 8'hE1;

  // Opcode matching on the fixed upper byte
  function automatic br_kind_t classify(input logic [15:0] w);
    if (w[15:8] == PFX_NOV)     return K_NOV;
    else if (w[15:8] == PFX_NZ) return K_NZ;
    else                        return K_NONE;
  endfunction

  // Branch condition: each branch looks only at its own flag
  function automatic logic cond_met(input br_kind_t k, input logic z, input logic ov);
    case (k)
      K_NOV:   return !ov;
      K_NZ:    return !z;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/relbr_seq.sv
module relbr_seq
  import relbr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output qphase_t phase_q
);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= Q1;
    else begin
      case (phase_q)
        Q1:      phase_q <= Q2;
        Q2:      phase_q <= Q3;
        Q3:      phase_q <= Q4;
        default: phase_q <= Q1;
      endcase
    end
  end

  // R6: phases advance one step per clock, wrapping Q4 -> Q1
  a_r6_phase_order: assert property (@(posedge clk) disable iff (rst)
    (phase_q == Q4) |=> (phase_q == Q1));
  a_r6_phase_step: assert property (@(posedge clk) disable iff (rst)
    (phase_q != Q4) |=> (2'(phase_q) == 2'($past(phase_q)) + 2'd1));

endmodule

// File: rtl/relbr_decode.sv
module relbr_decode
  import relbr_pkg::*;
#(
  parameter int IW    = 16,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  qphase_t          phase,
  input  logic             flush_q,
  input  logic [IW-1:0]    instr,
  output br_kind_t         kind_q,
  output logic [OFF_W-1:0] off_q
);

  logic [OFF_W-1:0] lit_q;

  // Q1 decodes; a flush cycle decodes nothing
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= K_NONE;
      lit_q  <= '0;
      off_q  <= '0;
    end else begin
      if (phase == Q1) begin
        kind_q <= flush_q ? K_NONE : classify(instr[15:0]);
        lit_q  <= instr[OFF_W-1:0];
      end
      if (phase == Q2) off_q <= lit_q;
    end
  end

  // R8: words presented during a flush cycle never become a branch
  a_r8_flush_no_decode: assert property (@(posedge clk) disable iff (rst)
    (phase == Q1 && flush_q) |=> (kind_q == K_NONE));

endmodule

// File: rtl/relbr_pcgen.sv
module relbr_pcgen
  import relbr_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  qphase_t          phase,
  input  br_kind_t         kind,
  input  logic [OFF_W-1:0] off,
  input  logic             flag_z,
  input  logic             flag_ov,
  output logic [PC_W-1:0]  pc_q,
  output logic             flush_q,
  output logic             take_evt,
  output logic             step_evt
);

  localparam logic [PC_W-1:0] WORD_BYTES = PC_W'(2);

  // Target arithmetic: word displacement doubled, relative to the next word
  function automatic logic [PC_W-1:0] calc_target(input logic [PC_W-1:0] base,
                                                  input logic [OFF_W-1:0] n);
    logic [PC_W-1:0] sx;
    sx = {{(PC_W-OFF_W){n[OFF_W-1]}}, n};
    return base + WORD_BYTES + (sx << 1);
  endfunction

  logic [PC_W-1:0] tgt_q;
  logic            take_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      tgt_q   <= '0;
      take_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (phase == Q3) begin
        tgt_q  <= calc_target(pc_q, off);
        take_q <= cond_met(kind, flag_z, flag_ov);
      end
      if (phase == Q4) begin
        if (flush_q) begin
          flush_q <= 1'b0;
        end else begin
          pc_q    <= take_q ? tgt_q : pc_q + WORD_BYTES;
          flush_q <= take_q;
        end
        take_q <= 1'b0;
      end
    end
  end

  assign take_evt = (phase == Q4) && take_q && !flush_q;
  assign step_evt = (phase == Q4) && !take_q && !flush_q;

  // R6: pc moves only at the end of Q4
  a_r6_pc_q4_only: assert property (@(posedge clk) disable iff (rst)
    (phase != Q4) |=> $stable(pc_q));
  // R5: a non-taken cycle steps by one word, no flush
  a_r5_step_two: assert property (@(posedge clk) disable iff (rst)
    step_evt |=> (pc_q == $past(pc_q) + WORD_BYTES) && !flush_q);
  // R8: taken branch opens a flush cycle
  a_r8_flush_follows: assert property (@(posedge clk) disable iff (rst)
    take_evt |=> flush_q);
  // R8: flush cycle holds pc and then closes
  a_r8_flush_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == Q4 && flush_q) |=> $stable(pc_q) && !flush_q);
  // R9: byte address stays word aligned
  a_r9_pc_even: assert property (@(posedge clk) disable iff (rst)
    pc_q[0] == 1'b0);

endmodule

// File: rtl/relbr_unit.sv
module relbr_unit
  import relbr_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int IW    = 16,
  parameter int OFF_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   instr_word,
  input  logic            flag_zero,
  input  logic            flag_ovf,
  output logic [PC_W-1:0] pc,
  output logic [1:0]      phase,
  output logic            taken,
  output logic            flush
);

  qphase_t          phase_q;
  br_kind_t         kind_q;
  logic [OFF_W-1:0] off_q;
  logic             flush_q;
  logic             take_evt;
  logic             step_evt;

  relbr_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .phase_q (phase_q)
  );

  relbr_decode #(.IW(IW), .OFF_W(OFF_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase_q),
    .flush_q (flush_q),
    .instr   (instr_word),
    .kind_q  (kind_q),
    .off_q   (off_q)
  );

  relbr_pcgen #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase_q),
    .kind     (kind_q),
    .off      (off_q),
    .flag_z   (flag_zero),
    .flag_ov  (flag_ovf),
    .pc_q     (pc),
    .flush_q  (flush_q),
    .take_evt (take_evt),
    .step_evt (step_evt)
  );

  assign phase = 2'(phase_q);
  assign taken = take_evt;
  assign flush = flush_q;

  // R7: taken is confined to Q4
  a_r7_taken_q4: assert property (@(posedge clk) disable iff (rst)
    taken |-> (phase == 2'd3));
  // R10: reset state after a reset edge
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (pc == '0) && (phase == 2'd0) && !flush);

endmodule

// File: tb/relbr_unit_test.sv
module relbr_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_word = 16'h0000;
  logic        flag_zero = 1'b0;
  logic        flag_ovf = 1'b0;
  logic [20:0] pc;
  logic [1:0]  phase;
  logic        taken;
  logic        flush;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [20:0] exp_pc = '0;

  always #5 clk = ~clk;

  relbr_unit uut (
    .clk(clk), .rst(rst), .instr_word(instr_word), .flag_zero(flag_zero),
    .flag_ovf(flag_ovf), .pc(pc), .phase(phase), .taken(taken), .flush(flush)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] model_target(input logic [20:0] p, input logic [7:0] n);
    int t;
    t = int'(p) + 2 + 2 * int'($signed(n));
    return t[20:0];
  endfunction

  // One instruction cycle, starting at a negedge in Q1
  task automatic run_word(input string req, input logic [15:0] w,
                          input logic z, input logic ov, input logic exp_take);
    instr_word = w; flag_zero = z; flag_ovf = ov;
    check({req, " phase Q1"}, 32'(phase), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({req, " R7 taken in Q4"}, 32'(taken), 32'(exp_take));
    check({req, " R6 pc held before Q4 end"}, 32'(pc), 32'(exp_pc));
    exp_pc = exp_take ? model_target(exp_pc, w[7:0]) : exp_pc + 21'd2;
    @(posedge clk);
    @(negedge clk);
    check({req, " pc after Q4"}, 32'(pc), 32'(exp_pc));
    check({req, " R8 flush flag"}, 32'(flush), 32'(exp_take));
    check({req, " R9 pc even"}, 32'(pc[0]), 0);
  endtask

  // Flush cycle presenting a word that would branch
  task automatic run_flush();
    instr_word = 16'hE1F0; flag_zero = 1'b0; flag_ovf = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R8 flush high each phase", 32'(flush), 1);
      check("R8 no taken in flush", 32'(taken), 0);
      @(posedge clk);
      @(negedge clk);
    end
    check("R8 pc held by flush", 32'(pc), 32'(exp_pc));
    check("R8 flush closes", 32'(flush), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_pc = '0;
    check("R10 pc reset", 32'(pc), 0);
    check("R10 phase reset", 32'(phase), 0);
    check("R10 flush reset", 32'(flush), 0);
  endtask

  task automatic t_wrap_negative();
    run_word("R4 R2 nz taken n=-2", 16'hE1FE, 1'b0, 1'b1, 1'b1);
    check("R2 wrap target", 32'(pc), 32'h1FFFFE);
    run_flush();
    run_word("R5 other word wraps", 16'h1234, 1'b0, 1'b0, 1'b0);
    check("R5 wrapped to zero", 32'(pc), 0);
  endtask

  task automatic t_extremes();
    run_word("R3 R2 nov taken n=+127", 16'hE57F, 1'b1, 1'b0, 1'b1);
    check("R2 +127 target", 32'(pc), 32'h100);
    run_flush();
    run_word("R3 R2 nov taken n=-128", 16'hE580, 1'b0, 1'b0, 1'b1);
    check("R2 -128 target", 32'(pc), 32'h2);
    run_flush();
  endtask

  task automatic t_not_taken();
    run_word("R3 nov not taken", 16'hE510, 1'b0, 1'b1, 1'b0);
    run_word("R4 nz not taken", 16'hE110, 1'b1, 1'b0, 1'b0);
    run_word("R1 E4 prefix ignored", 16'hE410, 1'b0, 1'b0, 1'b0);
    run_word("R1 E6 prefix ignored", 16'hE605, 1'b0, 1'b0, 1'b0);
    run_word("R1 A5 prefix ignored", 16'hA501, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    run_word("R4 nz taken +5", 16'hE105, 1'b0, 1'b1, 1'b1);
    run_flush();
    run_word("R3 nov taken -3", 16'hE5FD, 1'b1, 1'b0, 1'b1);
    run_flush();
  endtask

  task automatic t_reset_mid();
    instr_word = 16'hE140; flag_zero = 1'b0; flag_ovf = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    do_reset();
    run_word("R4 taken before flush reset", 16'hE140, 1'b0, 1'b0, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    do_reset();
    run_word("R10 normal after reset", 16'h0000, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_wrap_negative();
    t_extremes();
    t_not_taken();
    t_back_to_back();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule